// File: doc/BRIEF.md
# DMA and Interrupt Routing Register

This block is the glue logic of a synchronous serial adapter that sits on a 16-bit host I/O bus. It claims an 8-byte I/O window whose base is set by switch inputs. The low four offsets of the window are passed through to the serial controller. The block itself holds two byte-wide registers in the window: a routing register and a line-control register.

The routing register picks which controller request pin drives each host DMA request line, enables each DMA direction, and picks the interrupt source. The line-control register drives the line drivers, the receivers, the clock drivers and the two loopback controls. It also reports the test-mode input on a read-only bit.

Strap inputs model the board jumpers. One strap selects whether the interrupt line is shared, in which case the line is tri-stated while idle. The other strap selects whether the line drivers follow the register or stay on. An error flag reports two register settings that would harm the system. The outputs still follow the register contents when the flag is raised.

Top module: `dma_irq_router`

## Requirements
- R1: `board_hit` is 1 exactly when `bus_addr[15:3]` equals `base_sw`. `ctrl_sel` is 1 exactly when `board_hit` is 1 and `bus_addr[2:0]` is below 4.
- R2: A write (`bus_wr` high at a rising clock edge) to offset 5 loads bits 5:0 of the routing register, and a read of offset 5 returns `{2'b00, routing[5:0]}`. A write to offset 4 loads bits 5:0 of the line-control register, and a read of offset 4 returns `{test_mode, 1'b0, linectl[5:0]}`.
- R3: A write to offset 6 or 7, or to any address outside the window, changes neither register. Reads of offsets 0 to 3, 6 and 7 return 0.
- R4: Reset clears both registers to 0.
- R5: The transmit request source is routing bit 0. A value of 0 selects `req_a_wait` and a value of 1 selects `req_a_dtr`.
- R6: The receive request source is routing bit 1. A value of 0 selects `req_a_wait` and a value of 1 selects `req_b_wait`.
- R7: `dma_tx_req` is 0 whenever routing bit 2 is 0, and `dma_rx_req` is 0 whenever routing bit 3 is 0.
- R8: Routing bits 5:4 choose the interrupt source: 00 gives no interrupt, 01 selects `term_cnt`, 10 selects `ctrl_irq` and 11 selects `test_mode`. `irq_out` is active high.
- R9: When `strap_share` is 1, `irq_oe` equals `irq_out`. When `strap_share` is 0, `irq_oe` is always 1, and source 01 gives no interrupt.
- R10: When `strap_regctl` is 1, `tx_drv_en` follows line-control bit 0 and `rx_drv_en` follows bit 1. When `strap_regctl` is 0, both are 1.
- R11: The line-control bits drive the outputs as follows: bit 2 drives `txclk_drv_en`, bit 3 drives `rxclk_drv_en`, bit 4 drives `loop_remote` and bit 5 drives `loop_local`.
- R12: `cfg_err` is 1 when routing bits 1:0 are 00 and bits 3:2 are 11, or when line-control bits 5 and 4 are both 1. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| base_sw | input | 13 | Switch setting for address bits 15:3 |
| bus_addr | input | 16 | Host I/O address |
| bus_wdata | input | 8 | Host write data |
| bus_wr | input | 1 | Write strobe, sampled at clock edge |
| bus_rdata | output | 8 | Read data for the addressed board register |
| board_hit | output | 1 | Address falls in the window |
| ctrl_sel | output | 1 | Access is passed to the serial controller |
| req_a_wait | input | 1 | Channel A wait/request pin |
| req_a_dtr | input | 1 | Channel A DTR/request pin |
| req_b_wait | input | 1 | Channel B wait/request pin |
| ctrl_irq | input | 1 | Serial controller interrupt, active high |
| term_cnt | input | 1 | Host DMA terminal count |
| test_mode | input | 1 | Test-mode input |
| strap_share | input | 1 | Interrupt sharing strap |
| strap_regctl | input | 1 | Driver control taken from the register |
| dma_tx_req | output | 1 | Transmit DMA request to host |
| dma_rx_req | output | 1 | Receive DMA request to host |
| irq_out | output | 1 | Interrupt level |
| irq_oe | output | 1 | Interrupt output enable |
| tx_drv_en | output | 1 | Line transmitter enable |
| rx_drv_en | output | 1 | Line receiver enable |
| txclk_drv_en | output | 1 | Transmit clock driver enable |
| rxclk_drv_en | output | 1 | Receive clock driver enable |
| loop_local | output | 1 | Local loopback |
| loop_remote | output | 1 | Remote loopback |
| cfg_err | output | 1 | Harmful setting detected |

## Verification
The bench probes address decoding at the window edges, one byte below the window and one byte above it. A decoder that compared too few address bits would accept the neighbouring window. Writes to the reserved offsets and to a different base must leave both registers as they were; a design that ignored the offset bits would corrupt the routing register. Each request source is toggled while the other pins are held opposite, so a swapped multiplexer is caught.

The terminal-count interrupt is tried with and without the sharing strap. A design that lost the strap dependence would raise an interrupt in the non-shared mode, or would drive the line while idle in the shared mode. The bench also checks both error conditions, and checks that the outputs still follow the register while the flag is raised.

// File: rtl/dir_pkg.sv
package dir_pkg;
  localparam int ADDR_W   = 16;
  localparam int OFF_W    = 3;
  localparam int DATA_W   = 8;
  localparam int FIELD_W  = 6;
  localparam logic [OFF_W-1:0] OFF_LINE  = 3'd4;
  localparam logic [OFF_W-1:0] OFF_ROUTE = 3'd5;

  typedef enum logic [1:0] {
    IRQ_NONE = 2'b00,
    IRQ_TC   = 2'b01,
    IRQ_CTRL = 2'b10,
    IRQ_TEST = 2'b11
  } irq_src_e;

  typedef struct packed {
    logic [1:0] irq_sel;
    logic       rx_en;
    logic       tx_en;
    logic       rx_src;
    logic       tx_src;
  } route_t;

  typedef struct packed {
    logic loop_loc;
    logic loop_rem;
    logic rxclk;
    logic txclk;
    logic rx_on;
    logic tx_on;
  } line_t;
endpackage

// File: rtl/win_decode.sv
module win_decode #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 3,
  parameter int CTRL_N = 4
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic [ADDR_W-OFF_W-1:0] base,
  output logic                    hit,
  output logic                    ctrl,
  output logic [OFF_W-1:0]        offset
);
  localparam int SW_W = ADDR_W - OFF_W;

  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [SW_W-1:0] b);
    return a[ADDR_W-1:OFF_W] == b;
  endfunction

  assign offset = addr[OFF_W-1:0];
  assign hit    = in_window(addr, base);
  assign ctrl   = hit && (int'(offset) < CTRL_N);
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import dir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              hit,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] wdata,
  input  logic              test_mode,
  output route_t            route,
  output line_t             line,
  output logic [DATA_W-1:0] rdata
);
  logic wr_route, wr_line;
  assign wr_route = wr && hit && (offset == OFF_ROUTE);
  assign wr_line  = wr && hit && (offset == OFF_LINE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route <= '0;
      line  <= '0;
    end else begin
      if (wr_route) route <= route_t'(wdata[FIELD_W-1:0]);
      if (wr_line)  line  <= line_t'(wdata[FIELD_W-1:0]);
    end
  end

  always_comb begin
    rdata = '0;
    if (hit && offset == OFF_ROUTE) rdata = {2'b00, route};
    else if (hit && offset == OFF_LINE) rdata = {test_mode, 1'b0, line};
  end

  p_route_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_route |=> route == $past(wdata[FIELD_W-1:0]));
  p_reserved_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !(hit && offset == OFF_ROUTE)) |=> $stable(route));
endmodule

// File: rtl/dma_route.sv
module dma_route (
  input  logic tx_src,
  input  logic rx_src,
  input  logic tx_en,
  input  logic rx_en,
  input  logic a_wait,
  input  logic a_dtr,
  input  logic b_wait,
  output logic tx_req,
  output logic rx_req
);
  function automatic logic pick(input logic sel, input logic p0, input logic p1,
                                input logic en);
    return en && (sel ? p1 : p0);
  endfunction

  assign tx_req = pick(tx_src, a_wait, a_dtr, tx_en);
  assign rx_req = pick(rx_src, a_wait, b_wait, rx_en);
endmodule

// File: rtl/irq_route.sv
module irq_route
  import dir_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       share,
  input  logic       tc,
  input  logic       ctrl_irq,
  input  logic       test_mode,
  output logic       irq,
  output logic       oe
);
  function automatic logic irq_pick(input irq_src_e s, input logic sh,
                                    input logic t, input logic c, input logic m);
    case (s)
      IRQ_TC:   return sh && t;
      IRQ_CTRL: return c;
      IRQ_TEST: return m;
      default:  return 1'b0;
    endcase
  endfunction

  assign irq = irq_pick(irq_src_e'(sel), share, tc, ctrl_irq, test_mode);
  assign oe  = share ? irq : 1'b1;
endmodule

// File: rtl/dma_irq_router.sv
module dma_irq_router
  import dir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [12:0]       base_sw,
  input  logic [15:0]       bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  output logic [7:0]        bus_rdata,
  output logic              board_hit,
  output logic              ctrl_sel,
  input  logic              req_a_wait,
  input  logic              req_a_dtr,
  input  logic              req_b_wait,
  input  logic              ctrl_irq,
  input  logic              term_cnt,
  input  logic              test_mode,
  input  logic              strap_share,
  input  logic              strap_regctl,
  output logic              dma_tx_req,
  output logic              dma_rx_req,
  output logic              irq_out,
  output logic              irq_oe,
  output logic              tx_drv_en,
  output logic              rx_drv_en,
  output logic              txclk_drv_en,
  output logic              rxclk_drv_en,
  output logic              loop_local,
  output logic              loop_remote,
  output logic              cfg_err
);
  logic [OFF_W-1:0] offset;
  route_t route;
  line_t  line;
  logic   dma_clash, loop_clash;

  win_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .CTRL_N(4)) u_dec (
    .addr(bus_addr), .base(base_sw), .hit(board_hit), .ctrl(ctrl_sel),
    .offset(offset));

  reg_bank u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .hit(board_hit), .offset(offset),
    .wdata(bus_wdata), .test_mode(test_mode), .route(route), .line(line),
    .rdata(bus_rdata));

  dma_route u_dma (
    .tx_src(route.tx_src), .rx_src(route.rx_src), .tx_en(route.tx_en),
    .rx_en(route.rx_en), .a_wait(req_a_wait), .a_dtr(req_a_dtr),
    .b_wait(req_b_wait), .tx_req(dma_tx_req), .rx_req(dma_rx_req));

  irq_route u_irq (
    .sel(route.irq_sel), .share(strap_share), .tc(term_cnt),
    .ctrl_irq(ctrl_irq), .test_mode(test_mode), .irq(irq_out), .oe(irq_oe));

  assign tx_drv_en    = strap_regctl ? line.tx_on : 1'b1;
  assign rx_drv_en    = strap_regctl ? line.rx_on : 1'b1;
  assign txclk_drv_en = line.txclk;
  assign rxclk_drv_en = line.rxclk;
  assign loop_local   = line.loop_loc;
  assign loop_remote  = line.loop_rem;

  assign dma_clash  = !route.tx_src && !route.rx_src && route.tx_en && route.rx_en;
  assign loop_clash = line.loop_loc && line.loop_rem;
  assign cfg_err    = dma_clash || loop_clash;

  p_tx_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !route.tx_en |-> !dma_tx_req);
  p_rx_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !route.rx_en |-> !dma_rx_req);
  p_share_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_share && !irq_out) |-> !irq_oe);
  p_tc_needs_share_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!strap_share && route.irq_sel == IRQ_TC) |-> !irq_out);
  p_strap_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_regctl |-> (tx_drv_en && rx_drv_en));
  p_ctrl_in_win_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_sel |-> board_hit);
  p_reset_clear_r4: assert property (@(posedge clk)
    !rst_n |=> (route == '0 && line == '0));
endmodule

// File: tb/dma_irq_router_test.sv
module dma_irq_router_test;
  logic clk = 0, rst_n = 0;
  logic [12:0] base_sw = 13'h060;
  logic [15:0] bus_addr = 16'h0000;
  logic [7:0]  bus_wdata = 8'h00;
  logic bus_wr = 0;
  logic [7:0] bus_rdata;
  logic board_hit, ctrl_sel;
  logic req_a_wait = 0, req_a_dtr = 0, req_b_wait = 0;
  logic ctrl_irq = 0, term_cnt = 0, test_mode = 0;
  logic strap_share = 0, strap_regctl = 1;
  logic dma_tx_req, dma_rx_req, irq_out, irq_oe;
  logic tx_drv_en, rx_drv_en, txclk_drv_en, rxclk_drv_en, loop_local, loop_remote, cfg_err;
  int n_run = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_irq_router uut (.*);

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    req_a_wait = 1; req_a_dtr = 1; req_b_wait = 1;
    rd(16'h0305, d); chk(d, 8'h00, "R4 routing reg after reset");
    rd(16'h0304, d); chk(d, 8'h00, "R4 line reg after reset");
    chk({dma_tx_req, dma_rx_req}, 2'b00, "R4 R7 dma idle after reset");
    chk({tx_drv_en, rx_drv_en, loop_local}, 3'b000, "R4 drivers off after reset");
    chk({irq_out, irq_oe}, 2'b01, "R4 R9 irq idle unshared");
    req_a_wait = 0; req_a_dtr = 0; req_b_wait = 0;
  endtask

  task automatic t_decode;
    logic [7:0] d;
    rd(16'h0300, d); chk({board_hit, ctrl_sel}, 2'b11, "R1 offset 0");
    rd(16'h0303, d); chk({board_hit, ctrl_sel}, 2'b11, "R1 offset 3");
    rd(16'h0304, d); chk({board_hit, ctrl_sel}, 2'b10, "R1 offset 4");
    rd(16'h0307, d); chk({board_hit, ctrl_sel}, 2'b10, "R1 offset 7");
    rd(16'h02FF, d); chk({board_hit, ctrl_sel}, 2'b00, "R1 below window");
    rd(16'h0308, d); chk({board_hit, ctrl_sel}, 2'b00, "R1 above window");
    rd(16'h8300, d); chk({board_hit, ctrl_sel}, 2'b00, "R1 high bit differs");
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(16'h0305, 8'hFF); rd(16'h0305, d); chk(d, 8'h3F, "R2 routing readback");
    wr(16'h0305, 8'h2A); rd(16'h0305, d); chk(d, 8'h2A, "R2 routing pattern");
    test_mode = 1;
    wr(16'h0304, 8'hFF); rd(16'h0304, d); chk(d, 8'hBF, "R2 line readback test=1");
    test_mode = 0;
    wr(16'h0304, 8'h15); rd(16'h0304, d); chk(d, 8'h15, "R2 line pattern");
    wr(16'h0306, 8'h3F); wr(16'h0307, 8'h3F); wr(16'h030D, 8'h3F); wr(16'h0301, 8'h3F);
    rd(16'h0305, d); chk(d, 8'h2A, "R3 routing kept");
    rd(16'h0304, d); chk(d, 8'h15, "R3 line kept");
    rd(16'h0306, d); chk(d, 8'h00, "R3 reserved reads 0");
    rd(16'h0302, d); chk(d, 8'h00, "R3 controller offset reads 0");
  endtask

  task automatic t_dma;
    wr(16'h0305, 8'h0C);
    req_a_wait = 1; req_a_dtr = 0; req_b_wait = 0; #1;
    chk({dma_tx_req, dma_rx_req}, 2'b11, "R5 R6 both from A wait");
    wr(16'h0305, 8'h0D);
    req_a_wait = 0; req_a_dtr = 1; #1;
    chk(dma_tx_req, 1'b1, "R5 tx from A dtr");
    req_a_wait = 1; req_a_dtr = 0; #1;
    chk(dma_tx_req, 1'b0, "R5 tx ignores A wait");
    wr(16'h0305, 8'h0E);
    req_a_wait = 0; req_b_wait = 1; #1;
    chk({dma_tx_req, dma_rx_req}, 2'b01, "R6 rx from B wait");
    req_a_wait = 1; req_b_wait = 0; #1;
    chk({dma_tx_req, dma_rx_req}, 2'b10, "R6 rx ignores A wait, tx from A wait");
    wr(16'h0305, 8'h02);
    req_a_wait = 1; req_a_dtr = 1; req_b_wait = 1; #1;
    chk({dma_tx_req, dma_rx_req}, 2'b00, "R7 both disabled");
    wr(16'h0305, 8'h06); #1;
    chk({dma_tx_req, dma_rx_req}, 2'b10, "R7 only tx enabled");
    req_a_wait = 0; req_a_dtr = 0; req_b_wait = 0;
  endtask

  task automatic t_irq;
    strap_share = 1;
    wr(16'h0305, 8'h00); ctrl_irq = 1; term_cnt = 1; test_mode = 1; #1;
    chk({irq_out, irq_oe}, 2'b00, "R8 R9 source none, shared hi-z");
    wr(16'h0305, 8'h10); #1;
    chk({irq_out, irq_oe}, 2'b11, "R8 tc shared");
    term_cnt = 0; #1;
    chk({irq_out, irq_oe}, 2'b00, "R9 tc low shared released");
    wr(16'h0305, 8'h20); #1;
    chk(irq_out, 1'b1, "R8 controller source");
    ctrl_irq = 0; #1;
    chk(irq_out, 1'b0, "R8 controller low");
    wr(16'h0305, 8'h30); #1;
    chk(irq_out, 1'b1, "R8 test source");
    test_mode = 0; #1;
    chk(irq_out, 1'b0, "R8 test low");
    strap_share = 0; term_cnt = 1;
    wr(16'h0305, 8'h10); #1;
    chk({irq_out, irq_oe}, 2'b01, "R9 tc unshared gives nothing");
    term_cnt = 0;
    wr(16'h0305, 8'h00);
  endtask

  task automatic t_lines;
    strap_regctl = 1;
    wr(16'h0304, 8'h01); #1;
    chk({tx_drv_en, rx_drv_en}, 2'b10, "R10 tx only");
    wr(16'h0304, 8'h02); #1;
    chk({tx_drv_en, rx_drv_en}, 2'b01, "R10 rx only");
    strap_regctl = 0; wr(16'h0304, 8'h00); #1;
    chk({tx_drv_en, rx_drv_en}, 2'b11, "R10 strap forces on");
    wr(16'h0304, 8'h04); #1;
    chk({txclk_drv_en, rxclk_drv_en, loop_remote, loop_local}, 4'b1000, "R11 bit2 txclk");
    wr(16'h0304, 8'h08); #1;
    chk({txclk_drv_en, rxclk_drv_en, loop_remote, loop_local}, 4'b0100, "R11 bit3 rxclk");
    wr(16'h0304, 8'h10); #1;
    chk({txclk_drv_en, rxclk_drv_en, loop_remote, loop_local}, 4'b0010, "R11 bit4 remote");
    wr(16'h0304, 8'h20); #1;
    chk({txclk_drv_en, rxclk_drv_en, loop_remote, loop_local, cfg_err}, 5'b00010, "R11 R12 bit5 local");
  endtask

  task automatic t_err;
    wr(16'h0304, 8'h30); #1;
    chk({cfg_err, loop_local, loop_remote}, 3'b111, "R12 both loopbacks");
    wr(16'h0304, 8'h00);
    wr(16'h0305, 8'h0C); req_a_wait = 1; #1;
    chk({cfg_err, dma_tx_req, dma_rx_req}, 3'b111, "R12 shared A wait, outputs follow");
    wr(16'h0305, 8'h0E); #1;
    chk(cfg_err, 1'b0, "R12 legal combination");
    wr(16'h0305, 8'h04); #1;
    chk(cfg_err, 1'b0, "R12 one enable only");
    req_a_wait = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_decode();
    t_regs();
    t_dma();
    t_irq();
    t_lines();
    t_err();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule